// File: doc/BRIEF.md
# Piecewise-Linear Reciprocal Estimator

This unit takes a 64-bit IEEE-754 double and returns a bit-exact estimate of its reciprocal, also as a 64-bit double, carrying only single-precision significance. It does not compute a correctly rounded 1/x. The input significand chooses one of 32 segments through its top five fraction bits. Each segment supplies a starting value and a slope from constant tables. The next ten fraction bits then step down the segment linearly. The result exponent is the input exponent reflected about a fixed constant.

Inputs outside the range the tables cover get fixed outputs:
- zero gives a signed infinity and raises a divide-by-zero flag;
- infinity gives a signed zero;
- a NaN is passed through made quiet;
- tiny exponents saturate to the largest single-precision magnitude;
- huge exponents flush to signed zero.

A design that needs a paired (two-lane) estimate places two instances side by side. With the default parameters there is one register stage, and a valid bit travels with each operand.

Top module: `recip_est_unit`

## Requirements
- R1: For a normal-range input (biased exponent e, 895 ≤ e ≤ 1148), the result sign equals the input sign (bit 63) and the result exponent field (bits 62:52) equals 0x7FD − e.
- R2: An input with exponent field and fraction both zero (either sign) gives the infinity of the same sign (exponent 0x7FF, fraction 0) and drives out_zero_div high for that result.
- R3: out_zero_div is low for every valid result whose input was not a signed zero.
- R4: An infinite input (exponent 0x7FF, fraction 0) gives zero with the input sign.
- R5: A NaN input (exponent 0x7FF, fraction nonzero) is returned unchanged except that fraction bit 51 is forced to 1.
- R6: An input with biased exponent below 895, subnormals included, gives the input sign joined to the magnitude 0x47EFFFFFE0000000 (largest finite single-precision value as a double).
- R7: A finite input with biased exponent of 1149 or more gives zero with the input sign.
- R8: For normal-range inputs, let k = fraction bits 51:47 and m = fraction bits 46:37. The result bits 51:29 hold base[k] − ((slope[k]·m + 1) >> 1). For k = 0, base is 0x7FF800 and slope is 0x3E1. For k = 31, base is 0x020C00 and slope is 0x106.
- R9: For every input that is not a NaN, result bits 28:0 are zero.
- R10: out_valid is high exactly one cycle after in_valid was high, and it is low after reset.
- R11: out_result and out_zero_div keep their values in any cycle that follows a cycle with in_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Reciprocal estimate as a double |
| out_zero_div | output | 1 | Input was a signed zero |

## Verification
The bench targets the exponent boundaries 894/895 and 1148/1149. A design with an off-by-one comparison there would saturate, flush or interpolate on the wrong side. It drives both ends of the table, segment 0 at offset 0 and segment 31 at offset 1023. A dropped rounding bias or swapped table entries shows up there as a significand one or many units off. Signed zeros, infinities and NaNs are checked for sign handling and for the zero-divide flag, which a faulty decoder would raise for a subnormal. Random normal operands are compared against an independent model of the table formula. Idle cycles confirm that the outputs hold.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;
   localparam int unsigned DW        = 64;
   localparam int unsigned EXP_W     = 11;
   localparam int unsigned FRAC_W    = 52;
   localparam int unsigned SIG_W     = 23;
   localparam int unsigned SIG_LSB   = 29;
   localparam int unsigned SLOPE_W   = 10;

   localparam logic [EXP_W-1:0] EXP_ONES = '1;
   localparam logic [EXP_W-1:0] EXP_LO   = 11'd895;
   localparam logic [EXP_W-1:0] EXP_HI   = 11'd1149;
   localparam logic [EXP_W-1:0] EXP_REFL = 11'h7FD;
   localparam logic [DW-2:0]    MAX_SGL_MAG = 63'h47EF_FFFF_E000_0000;

   typedef enum logic [2:0] {
      CAT_NORM,
      CAT_ZERO,
      CAT_INF,
      CAT_NAN,
      CAT_TINY,
      CAT_HUGE
   } op_cat_e;
endpackage

// File: rtl/recip_est_rom.sv
module recip_est_rom
   import recip_est_pkg::*;
#(
   parameter int unsigned SEG_BITS = 5
) (
   input  logic [SEG_BITS-1:0] seg,
   output logic [SIG_W-1:0]    base,
   output logic [SLOPE_W-1:0]  slope
);
   always_comb begin
      unique case (seg)
         5'd0:  begin base = 23'h7FF800; slope = 10'h3E1; end
         5'd1:  begin base = 23'h783800; slope = 10'h3A7; end
         5'd2:  begin base = 23'h70EA00; slope = 10'h371; end
         5'd3:  begin base = 23'h6A0800; slope = 10'h340; end
         5'd4:  begin base = 23'h638800; slope = 10'h313; end
         5'd5:  begin base = 23'h5D6200; slope = 10'h2EA; end
         5'd6:  begin base = 23'h579000; slope = 10'h2C4; end
         5'd7:  begin base = 23'h520800; slope = 10'h2A0; end
         5'd8:  begin base = 23'h4CC800; slope = 10'h27F; end
         5'd9:  begin base = 23'h47CA00; slope = 10'h261; end
         5'd10: begin base = 23'h430800; slope = 10'h245; end
         5'd11: begin base = 23'h3E8000; slope = 10'h22A; end
         5'd12: begin base = 23'h3A2C00; slope = 10'h212; end
         5'd13: begin base = 23'h360800; slope = 10'h1FB; end
         5'd14: begin base = 23'h321400; slope = 10'h1E5; end
         5'd15: begin base = 23'h2E4A00; slope = 10'h1D1; end
         5'd16: begin base = 23'h2AA800; slope = 10'h1BE; end
         5'd17: begin base = 23'h272C00; slope = 10'h1AC; end
         5'd18: begin base = 23'h23D600; slope = 10'h19B; end
         5'd19: begin base = 23'h209E00; slope = 10'h18B; end
         5'd20: begin base = 23'h1D8800; slope = 10'h17C; end
         5'd21: begin base = 23'h1A9000; slope = 10'h16E; end
         5'd22: begin base = 23'h17AE00; slope = 10'h15B; end
         5'd23: begin base = 23'h14F800; slope = 10'h15B; end
         5'd24: begin base = 23'h124400; slope = 10'h143; end
         5'd25: begin base = 23'h0FBE00; slope = 10'h143; end
         5'd26: begin base = 23'h0D3800; slope = 10'h12D; end
         5'd27: begin base = 23'h0ADE00; slope = 10'h12D; end
         5'd28: begin base = 23'h088400; slope = 10'h11A; end
         5'd29: begin base = 23'h065000; slope = 10'h11A; end
         5'd30: begin base = 23'h041C00; slope = 10'h108; end
         default: begin base = 23'h020C00; slope = 10'h106; end
      endcase
   end
endmodule

// File: rtl/recip_est_interp.sv
module recip_est_interp
   import recip_est_pkg::*;
#(
   parameter int unsigned SEG_BITS = 5,
   parameter int unsigned OFS_BITS = 10
) (
   input  logic [SEG_BITS+OFS_BITS-1:0] idx,
   output logic [SIG_W-1:0]             sig
);
   localparam int unsigned PROD_W = SLOPE_W + OFS_BITS;

   logic [SEG_BITS-1:0] seg;
   logic [OFS_BITS-1:0] ofs;
   logic [SIG_W-1:0]    base;
   logic [SLOPE_W-1:0]  slope;
   logic [PROD_W-1:0]   prod;
   logic [PROD_W:0]     biased;

   assign seg = idx[SEG_BITS+OFS_BITS-1:OFS_BITS];
   assign ofs = idx[OFS_BITS-1:0];

   recip_est_rom #(.SEG_BITS(SEG_BITS)) rom_i (
      .seg   (seg),
      .base  (base),
      .slope (slope)
   );

   assign prod   = PROD_W'(slope) * PROD_W'(ofs);
   assign biased = {1'b0, prod} + {{PROD_W{1'b0}}, 1'b1};
   assign sig    = base - SIG_W'(biased[PROD_W:1]);
endmodule

// File: rtl/recip_est_classify.sv
module recip_est_classify
   import recip_est_pkg::*;
(
   input  logic [EXP_W-1:0]  exp_f,
   input  logic [FRAC_W-1:0] frac_f,
   output op_cat_e           cat
);
   logic frac_nz;
   assign frac_nz = |frac_f;

   always_comb begin
      if (exp_f == '0 && !frac_nz)   cat = CAT_ZERO;
      else if (exp_f == EXP_ONES)    cat = frac_nz ? CAT_NAN : CAT_INF;
      else if (exp_f < EXP_LO)       cat = CAT_TINY;
      else if (exp_f >= EXP_HI)      cat = CAT_HUGE;
      else                           cat = CAT_NORM;
   end
endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
   import recip_est_pkg::*;
#(
   parameter int unsigned SEG_BITS   = 5,
   parameter int unsigned OFS_BITS   = 10,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [63:0]   in_operand,
   output logic          out_valid,
   output logic [63:0]   out_result,
   output logic          out_zero_div
);
   localparam int unsigned IDX_W = SEG_BITS + OFS_BITS;

   generate
      if (SEG_BITS != 5 || OFS_BITS != 10) begin : g_bad_geom
         $error("recip_est_unit: tables are built for 5 segment bits and 10 offset bits");
      end
   endgenerate

   logic              sgn;
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   op_cat_e           cat;
   logic [SIG_W-1:0]  sig;
   logic [DW-1:0]     res_c;
   logic              zd_c;

   assign sgn    = in_operand[63];
   assign exp_f  = in_operand[62:52];
   assign frac_f = in_operand[51:0];

   recip_est_classify cls_i (
      .exp_f  (exp_f),
      .frac_f (frac_f),
      .cat    (cat)
   );

   recip_est_interp #(.SEG_BITS(SEG_BITS), .OFS_BITS(OFS_BITS)) interp_i (
      .idx (frac_f[FRAC_W-1 -: IDX_W]),
      .sig (sig)
   );

   always_comb begin
      zd_c = 1'b0;
      unique case (cat)
         CAT_ZERO: begin
            res_c = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
            zd_c  = 1'b1;
         end
         CAT_INF:  res_c = {sgn, {(DW-1){1'b0}}};
         CAT_NAN:  res_c = in_operand | (64'd1 << (FRAC_W-1));
         CAT_TINY: res_c = {sgn, MAX_SGL_MAG};
         CAT_HUGE: res_c = {sgn, {(DW-1){1'b0}}};
         default:  res_c = {sgn, EXP_REFL - exp_f, sig, {SIG_LSB{1'b0}}};
      endcase
   end

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid    <= 1'b0;
               out_result   <= '0;
               out_zero_div <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_result   <= res_c;
                  out_zero_div <= zd_c;
               end
            end
         end
      end else begin : g_comb
         assign out_valid    = in_valid;
         assign out_result   = res_c;
         assign out_zero_div = zd_c & in_valid;
      end
   endgenerate
endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk #(
   parameter bit REGISTERED = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [63:0] in_operand,
   input logic        out_valid,
   input logic [63:0] out_result,
   input logic        out_zero_div
);
   generate
      if (REGISTERED) begin : g_seq
         p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (out_valid == $past(in_valid)));

         p_zero_inf_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_operand[62:0] == 63'd0) |=>
               (out_zero_div && out_result[62:0] == 63'h7FF0_0000_0000_0000
                && out_result[63] == $past(in_operand[63])));

         p_flag_only_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_operand[62:0] != 63'd0) |=> !out_zero_div);

         p_inf_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_operand[62:0] == 63'h7FF0_0000_0000_0000) |=>
               (out_result == {$past(in_operand[63]), 63'd0}));

         p_sign_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_operand[62:52] != 11'h7FF) |=>
               (out_result[63] == $past(in_operand[63])));

         p_low_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_result[62:52] != 11'h7FF) |-> (out_result[28:0] == 29'd0));

         p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_result) && $stable(out_zero_div)));
      end
   endgenerate
endmodule

bind recip_est_unit recip_est_chk #(.REGISTERED(REGISTERED)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_operand   (in_operand),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_zero_div (out_zero_div)
);

// File: tb/recip_est_unit_tb_top.sv
module recip_est_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_operand = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_zero_div;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   recip_est_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_operand   (in_operand),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_zero_div (out_zero_div)
   );

   function automatic logic [22:0] m_base(input int k);
      logic [22:0] t [32] = '{
         23'h7FF800, 23'h783800, 23'h70EA00, 23'h6A0800, 23'h638800, 23'h5D6200,
         23'h579000, 23'h520800, 23'h4CC800, 23'h47CA00, 23'h430800, 23'h3E8000,
         23'h3A2C00, 23'h360800, 23'h321400, 23'h2E4A00, 23'h2AA800, 23'h272C00,
         23'h23D600, 23'h209E00, 23'h1D8800, 23'h1A9000, 23'h17AE00, 23'h14F800,
         23'h124400, 23'h0FBE00, 23'h0D3800, 23'h0ADE00, 23'h088400, 23'h065000,
         23'h041C00, 23'h020C00};
      return t[k];
   endfunction

   function automatic int m_slope(input int k);
      int t [32] = '{
         'h3E1, 'h3A7, 'h371, 'h340, 'h313, 'h2EA, 'h2C4, 'h2A0, 'h27F, 'h261, 'h245,
         'h22A, 'h212, 'h1FB, 'h1E5, 'h1D1, 'h1BE, 'h1AC, 'h19B, 'h18B, 'h17C, 'h16E,
         'h15B, 'h15B, 'h143, 'h143, 'h12D, 'h12D, 'h11A, 'h11A, 'h108, 'h106};
      return t[k];
   endfunction

   // Behavioural model written from R1..R8.
   function automatic logic [64:0] model(input logic [63:0] op);
      logic s = op[63];
      int   e = int'(op[62:52]);
      logic [51:0] f = op[51:0];
      longint sig;
      int k, m;
      if (e == 0 && f == 0)   return {1'b1, s, 11'h7FF, 52'd0};
      if (e == 2047)          return (f == 0) ? {1'b0, s, 63'd0} : {1'b0, op | 64'h0008_0000_0000_0000};
      if (e < 895)            return {1'b0, s, 63'h47EF_FFFF_E000_0000};
      if (e >= 1149)          return {1'b0, s, 63'd0};
      k = int'(f[51:47]);
      m = int'(f[46:37]);
      sig = longint'(m_base(k)) - ((longint'(m_slope(k)) * m + 1) / 2);
      return {1'b0, s, 11'(2045 - e), sig[22:0], 29'd0};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   // Issue one operand and check the registered result one cycle later.
   task automatic apply(input string req, input logic [63:0] op);
      logic [64:0] ex = model(op);
      @(negedge clk);
      in_valid = 1'b1; in_operand = op;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
      chk(req, out_result, ex[63:0]);
      chk({req, " zdiv"}, {63'd0, out_zero_div}, {63'd0, ex[64]});
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
      chk("R10 reset result", out_result, 64'd0);
   endtask

   task automatic t_specials;
      apply("R2 +zero", 64'h0000_0000_0000_0000);
      apply("R2 -zero", 64'h8000_0000_0000_0000);
      chk("R2 -zero literal", out_result, 64'hFFF0_0000_0000_0000);
      apply("R4 +inf", 64'h7FF0_0000_0000_0000);
      apply("R4 -inf", 64'hFFF0_0000_0000_0000);
      chk("R4 -inf literal", out_result, 64'h8000_0000_0000_0000);
      apply("R5 snan", 64'h7FF0_0000_0000_1235);
      chk("R5 snan literal", out_result, 64'h7FF8_0000_0000_1235);
      apply("R5 qnan", 64'hFFF8_0000_0000_0001);
      apply("R3 subnormal", 64'h0000_0000_0000_0001);
      chk("R3 subnormal no flag", {63'd0, out_zero_div}, 64'd0);
   endtask

   task automatic t_bounds;
      apply("R6 e=894", {1'b0, 11'd894, 52'h8_0000_0000_0000});
      chk("R6 e=894 literal", out_result, 64'h47EF_FFFF_E000_0000);
      apply("R6 -e=1", {1'b1, 11'd1, 52'd0});
      apply("R1 e=895", {1'b0, 11'd895, 52'd0});
      apply("R1 e=1148", {1'b1, 11'd1148, 52'd0});
      chk("R1 e=1148 exp", {53'd0, out_result[62:52]}, 64'd897);
      apply("R7 e=1149", {1'b1, 11'd1149, 52'd0});
      chk("R7 e=1149 literal", out_result, 64'h8000_0000_0000_0000);
      apply("R7 e=2046", {1'b0, 11'd2046, 52'hF_FFFF_FFFF_FFFF});
   endtask

   task automatic t_table;
      apply("R8 one", 64'h3FF0_0000_0000_0000);
      chk("R8 one literal", out_result, 64'h3FEF_FF00_0000_0000);
      apply("R8 k31 m1023", {1'b0, 11'd1023, 5'd31, 10'd1023, 37'h1F_FFFF_FFFF});
      chk("R8 k31 m1023 sig", {41'd0, out_result[51:29]}, 64'h83);
      chk("R9 low bits", {35'd0, out_result[28:0]}, 64'd0);
      apply("R8 k0 m1", {1'b0, 11'd1000, 5'd0, 10'd1, 37'd0});
      chk("R8 k0 m1 sig", {41'd0, out_result[51:29]}, 64'h7FF800 - 64'h1F1);
   endtask

   task automatic t_random;
      for (int i = 0; i < 300; i++) begin
         logic [10:0] e = 11'($urandom_range(895, 1148));
         logic [51:0] f = {20'($urandom), 32'($urandom)};
         apply("R8 random", {1'($urandom), e, f});
      end
   endtask

   task automatic t_hold;
      logic [63:0] prev;
      apply("R11 setup", 64'h4010_0000_0000_0000);
      prev = out_result;
      @(negedge clk);
      in_operand = 64'h0000_0000_0000_0000;
      @(negedge clk);
      chk("R10 idle valid", {63'd0, out_valid}, 64'd0);
      chk("R11 result held", out_result, prev);
      chk("R11 zdiv held", {63'd0, out_zero_div}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_specials();
      t_bounds();
      t_table();
      t_random();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule